// File: doc/BRIEF.md
# Control Endpoint Transfer Counters

This block keeps the running transfer state of a USB device's control endpoint in both directions. Software programs a byte count and a one-bit packet count for the IN and OUT directions, and for OUT a two-bit allowance of back-to-back SETUP packets. The counts then run down as the FIFO logic reports packet movement through strobes.

On IN, the byte count drops when a packet is copied from memory into the transmit FIFO. The packet count drops later, when that packet is drained from the FIFO onto the wire. On OUT, both counts drop when a received packet lands in the receive FIFO. A separate strobe consumes one SETUP allowance for each SETUP packet.

The block presents the live counts, a sticky completion flag for each direction with a write-one-to-clear input, an enable that says whether a SETUP packet may be taken, and a one-cycle reject pulse for a SETUP packet that arrives with no allowance left. A largest packet size register limits how much a single strobe can subtract.

Top module: `ep0_xfer_counters`

## Requirements
- R1: After reset the IN and OUT byte counts, packet counts, SETUP allowance, both completion flags, the accept enable and the reject pulse are all zero, and the largest packet size is 64.
- R2: A write to the IN group loads wr_size into the IN byte count and wr_pkt into the IN packet count. A write to the OUT group loads wr_size, wr_pkt and wr_setup into the OUT byte count, OUT packet count and SETUP allowance. A write to the size register loads wr_size as the largest packet size. Each value is visible on the outputs one cycle after the write.
- R3: in_fill_stb reduces the IN byte count by the smaller of in_fill_len and the largest packet size. The count stops at zero and does not wrap. This strobe leaves the IN packet count unchanged.
- R4: in_read_stb clears the IN packet count and leaves the IN byte count unchanged.
- R5: in_done is set when an IN fill takes a nonzero byte count to zero. It is not set by a fill that leaves bytes remaining, and it stays set until cleared.
- R6: out_wr_stb reduces the OUT byte count by the smaller of out_wr_len and the largest packet size, stopping at zero, and clears the OUT packet count.
- R7: out_done is set by out_wr_stb when out_wr_len is below the largest packet size (a short packet), or when the OUT byte count reaches zero. It stays set until cleared.
- R8: setup_stb with a nonzero allowance reduces the allowance by one. setup_en is high exactly when the allowance is nonzero.
- R9: setup_stb with a zero allowance leaves the allowance at zero and raises setup_rej for exactly the following cycle.
- R10: A write to a direction's register group in the same cycle as that direction's strobes takes priority, and the strobes of that cycle have no effect on that direction's counts, flags or reject pulse.
- R11: clr_in_done and clr_out_done clear their completion flags. A completion event in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_in | input | 1 | Load the IN group from wr_size and wr_pkt |
| wr_out | input | 1 | Load the OUT group from wr_size, wr_pkt and wr_setup |
| wr_mps | input | 1 | Load the largest packet size from wr_size |
| wr_size | input | 7 | Byte count or packet size write value |
| wr_pkt | input | 1 | Packet count write value |
| wr_setup | input | 2 | SETUP allowance write value (0 to 3 packets) |
| in_fill_stb | input | 1 | A packet was copied from memory into the transmit FIFO |
| in_fill_len | input | 7 | Length in bytes of that packet |
| in_read_stb | input | 1 | A packet was read out of the transmit FIFO |
| out_wr_stb | input | 1 | A packet was written into the receive FIFO |
| out_wr_len | input | 7 | Length in bytes of that packet |
| setup_stb | input | 1 | A SETUP packet arrived |
| clr_in_done | input | 1 | Write-one-to-clear for in_done |
| clr_out_done | input | 1 | Write-one-to-clear for out_done |
| in_xfer | output | 7 | Remaining IN byte count |
| in_pkt | output | 1 | Remaining IN packet count |
| out_xfer | output | 7 | Remaining OUT byte count |
| out_pkt | output | 1 | Remaining OUT packet count |
| setup_cnt | output | 2 | Remaining SETUP allowance |
| setup_en | output | 1 | A SETUP packet may be accepted |
| setup_rej | output | 1 | One-cycle pulse: a SETUP packet was rejected |
| in_done | output | 1 | Sticky IN completion flag |
| out_done | output | 1 | Sticky OUT completion flag |

## Verification
The bench aims at several corner cases. The first is a fill longer than the remaining bytes; a design that wraps instead of stopping would show a large count. The second is a packet length above the programmed packet size; a design that does not clamp would drain too much. The bench also sends a fill onto an already empty count, where a careless design would raise a second completion flag. Further cases are a register write colliding with a strobe, a clear colliding with a completion, and SETUP packets arriving after the allowance has run out; a design without the priority or reject logic would lose a write, drop a flag, or let the allowance underflow to three.

// File: rtl/ep0_xfer_counters.sv
module ep0_xfer_counters #(
  parameter int XW        = 7,
  parameter int SW        = 2,
  parameter int MPS_RESET = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_in,
  input  logic          wr_out,
  input  logic          wr_mps,
  input  logic [XW-1:0] wr_size,
  input  logic          wr_pkt,
  input  logic [SW-1:0] wr_setup,
  input  logic          in_fill_stb,
  input  logic [XW-1:0] in_fill_len,
  input  logic          in_read_stb,
  input  logic          out_wr_stb,
  input  logic [XW-1:0] out_wr_len,
  input  logic          setup_stb,
  input  logic          clr_in_done,
  input  logic          clr_out_done,
  output logic [XW-1:0] in_xfer,
  output logic          in_pkt,
  output logic [XW-1:0] out_xfer,
  output logic          out_pkt,
  output logic [SW-1:0] setup_cnt,
  output logic          setup_en,
  output logic          setup_rej,
  output logic          in_done,
  output logic          out_done
);

  localparam logic [XW-1:0] MPS_INIT = XW'(MPS_RESET);

  logic [XW-1:0] mps_q;
  logic [XW-1:0] in_x_q, out_x_q;
  logic          in_p_q, out_p_q;
  logic [SW-1:0] su_q;
  logic          in_d_q, out_d_q, rej_q;

  wire [XW-1:0] in_dec   = (in_fill_len > mps_q) ? mps_q : in_fill_len;
  wire [XW-1:0] out_dec  = (out_wr_len > mps_q) ? mps_q : out_wr_len;
  wire [XW-1:0] in_x_nx  = (in_dec >= in_x_q) ? '0 : in_x_q - in_dec;
  wire [XW-1:0] out_x_nx = (out_dec >= out_x_q) ? '0 : out_x_q - out_dec;
  wire          out_short = out_wr_len < mps_q;

  wire in_fill_ok  = in_fill_stb && !wr_in;
  wire out_wr_ok   = out_wr_stb && !wr_out;
  wire setup_ok    = setup_stb && !wr_out;
  wire in_finish   = in_fill_ok && (in_x_q != '0) && (in_x_nx == '0);
  wire out_finish  = out_wr_ok && (out_short || (out_x_nx == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mps_q   <= MPS_INIT;
      in_x_q  <= '0;
      in_p_q  <= 1'b0;
      out_x_q <= '0;
      out_p_q <= 1'b0;
      su_q    <= '0;
      in_d_q  <= 1'b0;
      out_d_q <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      if (wr_mps) mps_q <= wr_size;

      if (wr_in) begin
        in_x_q <= wr_size;
        in_p_q <= wr_pkt;
      end else begin
        if (in_fill_stb) in_x_q <= in_x_nx;
        if (in_read_stb) in_p_q <= 1'b0;
      end

      if (wr_out) begin
        out_x_q <= wr_size;
        out_p_q <= wr_pkt;
        su_q    <= wr_setup;
      end else begin
        if (out_wr_stb) begin
          out_x_q <= out_x_nx;
          out_p_q <= 1'b0;
        end
        if (setup_stb && su_q != '0) su_q <= su_q - 1'b1;
      end

      rej_q   <= setup_ok && (su_q == '0);
      in_d_q  <= (in_d_q && !clr_in_done) || in_finish;
      out_d_q <= (out_d_q && !clr_out_done) || out_finish;
    end
  end

  assign in_xfer   = in_x_q;
  assign in_pkt    = in_p_q;
  assign out_xfer  = out_x_q;
  assign out_pkt   = out_p_q;
  assign setup_cnt = su_q;
  assign setup_en  = su_q != '0;
  assign setup_rej = rej_q;
  assign in_done   = in_d_q;
  assign out_done  = out_d_q;

endmodule

// File: rtl/ep0_xfer_counters_chk.sv
module ep0_xfer_counters_chk #(
  parameter int XW = 7,
  parameter int SW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_in,
  input logic          wr_out,
  input logic [XW-1:0] wr_size,
  input logic          in_fill_stb,
  input logic          in_read_stb,
  input logic          out_wr_stb,
  input logic [XW-1:0] out_wr_len,
  input logic          setup_stb,
  input logic          clr_in_done,
  input logic [XW-1:0] in_xfer,
  input logic          in_pkt,
  input logic [SW-1:0] setup_cnt,
  input logic          setup_rej,
  input logic          in_done,
  input logic          out_done,
  input logic [XW-1:0] mps_q
);

  assert_fill_no_grow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_fill_stb && !wr_in |=> in_xfer <= $past(in_xfer));

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_read_stb && !wr_in |=> !in_pkt);

  assert_in_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_done && !clr_in_done |=> in_done);

  assert_short_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_wr_stb && !wr_out && (out_wr_len < mps_q) |=> out_done);

  assert_setup_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb && !wr_out && (setup_cnt != '0) |=> setup_cnt == $past(setup_cnt) - 1'b1);

  assert_setup_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    setup_stb && !wr_out && (setup_cnt == '0) |=> setup_rej && (setup_cnt == '0));

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |=> in_xfer == $past(wr_size));

endmodule

bind ep0_xfer_counters ep0_xfer_counters_chk #(.XW(XW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_in(wr_in), .wr_out(wr_out), .wr_size(wr_size),
  .in_fill_stb(in_fill_stb), .in_read_stb(in_read_stb), .out_wr_stb(out_wr_stb),
  .out_wr_len(out_wr_len), .setup_stb(setup_stb), .clr_in_done(clr_in_done),
  .in_xfer(in_xfer), .in_pkt(in_pkt), .setup_cnt(setup_cnt), .setup_rej(setup_rej),
  .in_done(in_done), .out_done(out_done), .mps_q(mps_q)
);

// File: tb/test_ep0_xfer_counters.sv
`timescale 1ns/1ps
module test_ep0_xfer_counters;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_in = 0, wr_out = 0, wr_mps = 0;
  logic [6:0] wr_size = '0;
  logic wr_pkt = 0;
  logic [1:0] wr_setup = '0;
  logic in_fill_stb = 0, in_read_stb = 0, out_wr_stb = 0, setup_stb = 0;
  logic [6:0] in_fill_len = '0, out_wr_len = '0;
  logic clr_in_done = 0, clr_out_done = 0;
  logic [6:0] in_xfer, out_xfer;
  logic in_pkt, out_pkt, setup_en, setup_rej, in_done, out_done;
  logic [1:0] setup_cnt;

  always #5 clk = ~clk;

  ep0_xfer_counters i_ep0_xfer_counters (
    .clk(clk), .rst_n(rst_n), .wr_in(wr_in), .wr_out(wr_out), .wr_mps(wr_mps),
    .wr_size(wr_size), .wr_pkt(wr_pkt), .wr_setup(wr_setup),
    .in_fill_stb(in_fill_stb), .in_fill_len(in_fill_len), .in_read_stb(in_read_stb),
    .out_wr_stb(out_wr_stb), .out_wr_len(out_wr_len), .setup_stb(setup_stb),
    .clr_in_done(clr_in_done), .clr_out_done(clr_out_done),
    .in_xfer(in_xfer), .in_pkt(in_pkt), .out_xfer(out_xfer), .out_pkt(out_pkt),
    .setup_cnt(setup_cnt), .setup_en(setup_en), .setup_rej(setup_rej),
    .in_done(in_done), .out_done(out_done)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit started = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_mps, m_ix, m_ip, m_ox, m_op, m_su, m_id, m_od, m_rej;
  always @(posedge clk) begin
    int take_in, take_out, nin, nout, rej, idn, odn;
    if (!rst_n) begin
      m_mps = 64; m_ix = 0; m_ip = 0; m_ox = 0; m_op = 0; m_su = 0;
      m_id = 0; m_od = 0; m_rej = 0; started = 1;
    end else begin
      take_in  = (int'(in_fill_len) < m_mps) ? int'(in_fill_len) : m_mps;
      take_out = (int'(out_wr_len) < m_mps) ? int'(out_wr_len) : m_mps;
      nin  = m_ix - take_in;  if (nin < 0) nin = 0;
      nout = m_ox - take_out; if (nout < 0) nout = 0;
      rej = 0; idn = 0; odn = 0;
      if (wr_in) begin
        m_ix = wr_size; m_ip = wr_pkt;
      end else begin
        if (in_fill_stb) begin
          if (m_ix > 0 && nin == 0) idn = 1;
          m_ix = nin;
        end
        if (in_read_stb) m_ip = 0;
      end
      if (wr_out) begin
        m_ox = wr_size; m_op = wr_pkt; m_su = wr_setup;
      end else begin
        if (out_wr_stb) begin
          if (int'(out_wr_len) < m_mps || nout == 0) odn = 1;
          m_ox = nout; m_op = 0;
        end
        if (setup_stb) begin
          if (m_su > 0) m_su = m_su - 1; else rej = 1;
        end
      end
      if (wr_mps) m_mps = wr_size;
      m_rej = rej;
      m_id = ((m_id == 1) && !clr_in_done) || (idn == 1) ? 1 : 0;
      m_od = ((m_od == 1) && !clr_out_done) || (odn == 1) ? 1 : 0;
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R3 in_xfer", in_xfer, m_ix);
      chk("R4 in_pkt", in_pkt, m_ip);
      chk("R5 in_done", in_done, m_id);
      chk("R6 out_xfer", out_xfer, m_ox);
      chk("R6 out_pkt", out_pkt, m_op);
      chk("R7 out_done", out_done, m_od);
      chk("R8 setup_cnt", setup_cnt, m_su);
      chk("R8 setup_en", setup_en, (m_su != 0) ? 1 : 0);
      chk("R9 setup_rej", setup_rej, m_rej);
    end
  end

  task automatic idle();
    wr_in = 0; wr_out = 0; wr_mps = 0; in_fill_stb = 0; in_read_stb = 0;
    out_wr_stb = 0; setup_stb = 0; clr_in_done = 0; clr_out_done = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 in_xfer", in_xfer, 0);
    chk("R1 out_xfer", out_xfer, 0);
    chk("R1 setup_en", setup_en, 0);
    chk("R1 done", {in_done, out_done, setup_rej}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 register loads
    wr_in = 1; wr_out = 1; wr_size = 7'd100; wr_pkt = 1; wr_setup = 2'd3;
    @(negedge clk); idle();
    chk("R2 in_xfer", in_xfer, 100);
    chk("R2 out_xfer", out_xfer, 100);
    chk("R2 setup_cnt", setup_cnt, 3);
    chk("R2 in_pkt", in_pkt, 1);

    // R3 clamp to 64, then saturation; R5 flag only on reaching zero
    in_fill_stb = 1; in_fill_len = 7'd120;
    @(negedge clk); idle();
    chk("R3 clamp", in_xfer, 36);
    chk("R5 not yet", in_done, 0);
    in_fill_stb = 1; in_fill_len = 7'd50;
    @(negedge clk); idle();
    chk("R3 saturate", in_xfer, 0);
    chk("R5 set", in_done, 1);
    chk("R3 pkt kept", in_pkt, 1);
    in_read_stb = 1;
    @(negedge clk); idle();
    chk("R4 pkt clear", in_pkt, 0);
    // R11 clear, then fill on empty count does not set
    clr_in_done = 1; in_fill_stb = 1; in_fill_len = 7'd5;
    @(negedge clk); idle();
    chk("R11 clear", in_done, 0);

    // R6/R7 full packet then short packet
    out_wr_stb = 1; out_wr_len = 7'd64;
    @(negedge clk); idle();
    chk("R6 out dec", out_xfer, 36);
    chk("R7 full no done", out_done, 0);
    out_wr_stb = 1; out_wr_len = 7'd10;
    @(negedge clk); idle();
    chk("R7 short done", out_done, 1);
    chk("R6 out dec2", out_xfer, 26);

    // R11 set beats clear
    clr_out_done = 1; out_wr_stb = 1; out_wr_len = 7'd3;
    @(negedge clk); idle();
    chk("R11 set wins", out_done, 1);

    // R8/R9 SETUP allowance
    repeat (3) begin
      setup_stb = 1;
      @(negedge clk); idle();
    end
    chk("R8 used up", setup_en, 0);
    setup_stb = 1;
    @(negedge clk); idle();
    chk("R9 reject", setup_rej, 1);
    chk("R9 stays zero", setup_cnt, 0);
    @(negedge clk);
    chk("R9 one cycle", setup_rej, 0);

    // R10 write beats strobes
    wr_out = 1; wr_size = 7'd20; wr_pkt = 1; wr_setup = 2'd0;
    setup_stb = 1; out_wr_stb = 1; out_wr_len = 7'd4; clr_out_done = 1;
    @(negedge clk); idle();
    chk("R10 out_xfer", out_xfer, 20);
    chk("R10 out_pkt", out_pkt, 1);
    chk("R10 no reject", setup_rej, 0);
    chk("R10 flag cleared only", out_done, 0);

    // R2 packet size register
    wr_mps = 1; wr_size = 7'd8;
    @(negedge clk); idle();
    out_wr_stb = 1; out_wr_len = 7'd30;
    @(negedge clk); idle();
    chk("R2 mps clamp", out_xfer, 12);

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      wr_in = ($urandom % 16) == 0;
      wr_out = ($urandom % 16) == 0;
      wr_mps = ($urandom % 64) == 0;
      wr_size = 7'($urandom);
      wr_pkt = 1'($urandom);
      wr_setup = 2'($urandom);
      in_fill_stb = ($urandom % 3) == 0;
      in_fill_len = 7'($urandom);
      in_read_stb = ($urandom % 4) == 0;
      out_wr_stb = ($urandom % 3) == 0;
      out_wr_len = 7'($urandom);
      setup_stb = ($urandom % 3) == 0;
      clr_in_done = ($urandom % 8) == 0;
      clr_out_done = ($urandom % 8) == 0;
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    finish_run();
  end

endmodule